// File: doc/BRIEF.md
# SM3 Two-Round Compression Unit

This unit advances the SM3 hash compression by two consecutive rounds per accepted operation. The caller supplies the eight 32-bit chaining words split across two 128-bit operands. One operand holds the A, B, E and F words and the other holds C, D, G and H. A third 128-bit operand carries four message-derived words, and an 8-bit round selector gives the first round of the pair. The unit returns the new A, B, E and F words packed into one 128-bit result. The caller rebuilds the other four words from the state it already holds.

The C, D, G and H words come in unrotated, and the unit rotates them itself before the first round. The round constant and the choice of boolean functions both follow from an even effective round number, which is taken from the selector byte. Both rounds are evaluated combinationally and the packed result is captured in an output register. The input side accepts one operation per clock and never stalls.

Top module: `sm3_dual_round`

## Requirements
- R1: Input state words are unpacked as A = `st_abef[127:96]`, B = `st_abef[95:64]`, E = `st_abef[63:32]`, F = `st_abef[31:0]`, C = `st_cdgh[127:96]`, D = `st_cdgh[95:64]`, G = `st_cdgh[63:32]`, H = `st_cdgh[31:0]`.
- R2: Before the first round, C and D are rotated left by 9 bits, and G and H are rotated left by 19 bits.
- R3: Message lanes are used as follows, with lane k being `msg[32k+31:32k]`. Round 0 uses lane 0 as its plain word and lane 0 XOR lane 2 as its mixed word. Round 1 uses lane 1 as its plain word and lane 1 XOR lane 3 as its mixed word.
- R4: The effective round number is `round_sel & 8'h3E`, so it is even and lies in 0..62. Bits 0, 6 and 7 of `round_sel` have no effect on the result.
- R5: The constant base is 32'h79CC4519 when the effective round is below 16 and 32'h7A879D8A otherwise. The first round uses the base rotated left by (effective round mod 32). The second round uses that value rotated left by one more bit.
- R6: When the effective round is below 16, both rounds use XOR of three operands for both boolean functions. Otherwise the A-side function is majority, and the E-side function is (x AND y) OR (NOT x AND z). The class of the effective round applies to both rounds.
- R7: Each round, with all sums taken mod 2^32, computes S1 = rotl(rotl(A,12)+E+K,7) and S2 = S1 XOR rotl(A,12). It then computes T1 = FFn(A,B,C)+D+S2+mixed word and T2 = GGn(E,F,G)+H+S1+plain word. The state is then shifted: D gets C, C gets rotl(B,9), B gets A, A gets T1, H gets G, G gets rotl(F,19), F gets E, and E gets T2 XOR rotl(T2,9) XOR rotl(T2,17).
- R8: After the second round, `out_state` holds A in bits [127:96], B in [95:64], E in [63:32] and F in [31:0].
- R9: `in_ready` is always 1. `out_valid` is 1 exactly in the cycle after a cycle in which `in_valid` was 1 outside reset.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_state` to zero at the next clock edge. This holds even when `in_valid` is high.
- R11: In cycles without an accepted input, `out_state` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| in_ready | output | 1 | Always high; every valid input is taken |
| st_cdgh | input | 128 | Unrotated C, D, G, H state words |
| st_abef | input | 128 | A, B, E, F state words |
| msg | input | 128 | Four message-derived words |
| round_sel | input | 8 | First round number of the pair (masked) |
| out_valid | output | 1 | Result register holds a new result |
| out_state | output | 128 | Updated A, B, E, F after two rounds |

## Verification
Each result is due exactly one clock edge after the cycle that accepts it. The effect of reset is also due one edge after it is applied, and in idle cycles the previous result must still be held at that same edge. The bench drives inputs on the falling edge and advances a behavioural model by one step per cycle. On the next falling edge it compares `out_valid` and `out_state` with that model. The comparison therefore always lands on the first edge at which the output register could have changed. Directed operands isolate the pre-rotation, the message lanes, the masked selector bits and the constant and function-class boundary at round 16. Random operands across many round numbers cover the general round update.

// File: rtl/sm3_rnd_pkg.sv
package sm3_rnd_pkg;

   localparam int WORD_W = 32;

   typedef logic [WORD_W-1:0] word_t;

   typedef struct packed {
      word_t a;
      word_t b;
      word_t c;
      word_t d;
      word_t e;
      word_t f;
      word_t g;
      word_t h;
   } sm3_st_t;

   // rotate left by n modulo the word width
   function automatic word_t rotl(input word_t v, input int unsigned n);
      logic [2*WORD_W-1:0] dbl;
      dbl = {v, v} << (n % WORD_W);
      return dbl[2*WORD_W-1 -: WORD_W];
   endfunction

   function automatic word_t perm0(input word_t v);
      return v ^ rotl(v, 9) ^ rotl(v, 17);
   endfunction

   // A-side boolean function: parity in the low class, majority otherwise
   function automatic word_t bool_a(input word_t x, input word_t y,
                                    input word_t z, input logic hi);
      return hi ? ((x & y) | (x & z) | (y & z)) : (x ^ y ^ z);
   endfunction

   // E-side boolean function: parity in the low class, select otherwise
   function automatic word_t bool_e(input word_t x, input word_t y,
                                    input word_t z, input logic hi);
      return hi ? ((x & y) | (~x & z)) : (x ^ y ^ z);
   endfunction

endpackage

// File: rtl/sm3_round_const.sv
module sm3_round_const
   import sm3_rnd_pkg::*;
#(
   parameter int          SEL_W  = 8,
   parameter logic [7:0]  MASK   = 8'h3E,
   parameter int          SPLIT  = 16,
   parameter word_t       K_LOW  = 32'h79CC4519,
   parameter word_t       K_HIGH = 32'h7A879D8A,
   parameter int          STEPS  = 2
) (
   input  logic [SEL_W-1:0]              round_sel,
   output logic                          high_class,
   output logic [STEPS-1:0][WORD_W-1:0]  k_step
);

   generate
      if (MASK[0] != 1'b0) begin : g_bad_mask
         $error("sm3_round_const: MASK must keep the round number even");
      end
      if (SEL_W != 8) begin : g_bad_sel
         $error("sm3_round_const: SEL_W must be 8");
      end
   endgenerate

   logic [SEL_W-1:0] eff_round;
   word_t            base_k;
   word_t            first_k;

   always_comb begin
      eff_round  = round_sel & MASK;
      high_class = (int'(eff_round) >= SPLIT);
      base_k     = high_class ? K_HIGH : K_LOW;
      first_k    = rotl(base_k, int'(eff_round));
   end

   generate
      for (genvar s = 0; s < STEPS; s++) begin : g_k
         assign k_step[s] = rotl(first_k, s);
      end
   endgenerate

endmodule

// File: rtl/sm3_round_step.sv
module sm3_round_step
   import sm3_rnd_pkg::*;
(
   input  sm3_st_t st_in,
   input  logic    high_class,
   input  word_t   k_const,
   input  word_t   w_plain,
   input  word_t   w_far,
   output sm3_st_t st_out
);

   word_t a_rot;
   word_t s1;
   word_t s2;
   word_t t1;
   word_t t2;

   always_comb begin
      a_rot = rotl(st_in.a, 12);
      s1    = rotl(a_rot + st_in.e + k_const, 7);
      s2    = s1 ^ a_rot;
      t1    = bool_a(st_in.a, st_in.b, st_in.c, high_class) + st_in.d + s2
              + (w_plain ^ w_far);
      t2    = bool_e(st_in.e, st_in.f, st_in.g, high_class) + st_in.h + s1
              + w_plain;

      st_out.a = t1;
      st_out.b = st_in.a;
      st_out.c = rotl(st_in.b, 9);
      st_out.d = st_in.c;
      st_out.e = perm0(t2);
      st_out.f = st_in.e;
      st_out.g = rotl(st_in.f, 19);
      st_out.h = st_in.g;
   end

endmodule

// File: rtl/sm3_dual_round.sv
module sm3_dual_round
   import sm3_rnd_pkg::*;
#(
   parameter int         OP_W       = 128,
   parameter int         SEL_W      = 8,
   parameter logic [7:0] ROUND_MASK = 8'h3E,
   parameter int         CLASS_SPLIT = 16,
   parameter word_t      K_LOW      = 32'h79CC4519,
   parameter word_t      K_HIGH     = 32'h7A879D8A
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [OP_W-1:0]   st_cdgh,
   input  logic [OP_W-1:0]   st_abef,
   input  logic [OP_W-1:0]   msg,
   input  logic [SEL_W-1:0]  round_sel,
   output logic              out_valid,
   output logic [OP_W-1:0]   out_state
);

   localparam int LANES = OP_W / WORD_W;
   localparam int STEPS = LANES / 2;

   generate
      if (OP_W != 4 * WORD_W) begin : g_bad_width
         $error("sm3_dual_round: OP_W must hold exactly four words");
      end
   endgenerate

   logic                          high_class;
   logic [STEPS-1:0][WORD_W-1:0]  k_step;
   sm3_st_t                       st [STEPS+1];
   logic [OP_W-1:0]               result;
   logic                          accept;

   assign in_ready = 1'b1;
   assign accept   = in_valid & in_ready;

   sm3_round_const #(
      .SEL_W  (SEL_W),
      .MASK   (ROUND_MASK),
      .SPLIT  (CLASS_SPLIT),
      .K_LOW  (K_LOW),
      .K_HIGH (K_HIGH),
      .STEPS  (STEPS)
   ) u_const (
      .round_sel  (round_sel),
      .high_class (high_class),
      .k_step     (k_step)
   );

   // operand unpacking with pre-rotation of the unrotated words
   always_comb begin
      st[0].a = st_abef[3*WORD_W +: WORD_W];
      st[0].b = st_abef[2*WORD_W +: WORD_W];
      st[0].e = st_abef[1*WORD_W +: WORD_W];
      st[0].f = st_abef[0*WORD_W +: WORD_W];
      st[0].c = rotl(st_cdgh[3*WORD_W +: WORD_W], 9);
      st[0].d = rotl(st_cdgh[2*WORD_W +: WORD_W], 9);
      st[0].g = rotl(st_cdgh[1*WORD_W +: WORD_W], 19);
      st[0].h = rotl(st_cdgh[0*WORD_W +: WORD_W], 19);
   end

   generate
      for (genvar s = 0; s < STEPS; s++) begin : g_step
         sm3_round_step u_step (
            .st_in      (st[s]),
            .high_class (high_class),
            .k_const    (k_step[s]),
            .w_plain    (msg[s*WORD_W +: WORD_W]),
            .w_far      (msg[(s+STEPS)*WORD_W +: WORD_W]),
            .st_out     (st[s+1])
         );
      end
   endgenerate

   assign result = {st[STEPS].a, st[STEPS].b, st[STEPS].e, st[STEPS].f};

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_state <= '0;
      end else begin
         out_valid <= accept;
         if (accept) begin
            out_state <= result;
         end
      end
   end

   // R9: result flagged one edge after an accepted input
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
      accept |=> out_valid);

   // R9: no result flag without an accepted input
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
      !accept |=> !out_valid);

   // R11: stored result unchanged in idle cycles
   a_r11_hold: assert property (@(posedge clk) disable iff (rst)
      !accept |=> $stable(out_state));

   // R8: lane 2 carries the A word produced by the first round
   a_r8_lane_b: assert property (@(posedge clk) disable iff (rst)
      accept |=> out_state[2*WORD_W +: WORD_W] == $past(st[1].a));

   // R8: lane 0 carries the E word produced by the first round
   a_r8_lane_f: assert property (@(posedge clk) disable iff (rst)
      accept |=> out_state[0 +: WORD_W] == $past(st[1].e));

endmodule

// File: tb/tb_sm3_dual_round.sv
`timescale 1ns/1ps
module tb_sm3_dual_round;

   logic         clk = 1'b0;
   logic         rst;
   logic         in_valid;
   logic         in_ready;
   logic [127:0] st_cdgh;
   logic [127:0] st_abef;
   logic [127:0] msg;
   logic [7:0]   round_sel;
   logic         out_valid;
   logic [127:0] out_state;

   always #5 clk = ~clk;

   sm3_dual_round dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .st_cdgh   (st_cdgh),
      .st_abef   (st_abef),
      .msg       (msg),
      .round_sel (round_sel),
      .out_valid (out_valid),
      .out_state (out_state)
   );

   int           n_checks = 0;
   int           n_fails  = 0;
   logic         exp_valid = 1'b0;
   logic [127:0] exp_state = '0;
   string        data_tag = "R10";
   string        valid_tag = "R10";
   logic         done = 1'b0;

   function automatic logic [31:0] rl(input logic [31:0] v, input int n);
      if (n == 0) return v;
      return (v << n) | (v >> (32 - n));
   endfunction

   // behavioural model of one two-round operation
   function automatic logic [127:0] ref_op(input logic [127:0] x,
                                           input logic [127:0] y,
                                           input logic [127:0] m,
                                           input logic [7:0]   rb);
      logic [31:0] v [8];
      logic [31:0] k, a12, s1, s2, fa, fe, t1, t2, wp, wf;
      int r;
      r = int'(rb & 8'h3E);
      k = (r < 16) ? 32'h79CC4519 : 32'h7A879D8A;
      k = rl(k, r % 32);
      v[0] = y[127:96];        v[1] = y[95:64];
      v[2] = rl(x[127:96], 9); v[3] = rl(x[95:64], 9);
      v[4] = y[63:32];         v[5] = y[31:0];
      v[6] = rl(x[63:32], 19); v[7] = rl(x[31:0], 19);
      for (int i = 0; i < 2; i++) begin
         wp  = m[32*i +: 32];
         wf  = m[32*(i+2) +: 32];
         a12 = rl(v[0], 12);
         s1  = rl(a12 + v[4] + k, 7);
         s2  = s1 ^ a12;
         if (r < 16) begin
            fa = v[0] ^ v[1] ^ v[2];
            fe = v[4] ^ v[5] ^ v[6];
         end else begin
            fa = (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
            fe = (v[4] & v[5]) | (~v[4] & v[6]);
         end
         t1 = fa + v[3] + s2 + (wp ^ wf);
         t2 = fe + v[7] + s1 + wp;
         v[3] = v[2]; v[2] = rl(v[1], 9); v[1] = v[0]; v[0] = t1;
         v[7] = v[6]; v[6] = rl(v[5], 19); v[5] = v[4];
         v[4] = t2 ^ rl(t2, 9) ^ rl(t2, 17);
         k = rl(k, 1);
      end
      return {v[0], v[1], v[4], v[5]};
   endfunction

   task automatic compare();
      n_checks++;
      if (in_ready !== 1'b1) begin
         n_fails++;
         $display("FAIL R9 in_ready actual %b expected 1", in_ready);
      end
      n_checks++;
      if (out_valid !== exp_valid) begin
         n_fails++;
         $display("FAIL %s out_valid actual %b expected %b", valid_tag, out_valid, exp_valid);
      end
      n_checks++;
      if (out_state !== exp_state) begin
         n_fails++;
         $display("FAIL %s out_state actual %h expected %h", data_tag, out_state, exp_state);
      end
   endtask

   // one cycle: check the previous edge, drive new inputs, step the model
   task automatic cyc(input logic v, input logic [127:0] x, input logic [127:0] y,
                      input logic [127:0] m, input logic [7:0] rb,
                      input string tag, input logic r = 1'b0);
      @(negedge clk);
      compare();
      rst       = r;
      in_valid  = v;
      st_cdgh   = x;
      st_abef   = y;
      msg       = m;
      round_sel = rb;
      if (r) begin
         exp_valid = 1'b0;
         exp_state = '0;
         valid_tag = "R10";
         data_tag  = "R10";
      end else begin
         exp_valid = v;
         valid_tag = "R9";
         if (v) begin
            exp_state = ref_op(x, y, m, rb);
            data_tag  = tag;
         end else begin
            data_tag  = "R11";
         end
      end
   endtask

   function automatic logic [127:0] rnd128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   initial begin
      rst = 1'b1; in_valid = 1'b0; st_cdgh = '0; st_abef = '0; msg = '0; round_sel = '0;
      void'($urandom(32'h5a3c));
      // R10: reset state
      cyc(1'b0, '0, '0, '0, 8'd0, "R10", 1'b1);
      cyc(1'b1, rnd128(), rnd128(), rnd128(), 8'd4, "R10", 1'b1);
      // R1 / R8: plain operands, single lane set
      cyc(1'b1, '0, 128'h00000001_00000000_00000000_00000000, '0, 8'd0, "R1");
      cyc(1'b1, '0, 128'h00000000_00000000_00000001_00000000, '0, 8'd0, "R8");
      cyc(1'b1, '0, 128'h00000000_00000002_00000000_00000080, '0, 8'd20, "R1");
      // R2: only C/D/G/H lanes set
      cyc(1'b1, 128'h80000000_00000000_00000000_00000000, '0, '0, 8'd0, "R2");
      cyc(1'b1, 128'h00000000_00000000_00000000_00010000, '0, '0, 8'd18, "R2");
      cyc(1'b1, 128'h00000000_12345678_9abcdef0_00000000, '0, '0, 8'd2, "R2");
      // R3: only message lanes set
      cyc(1'b1, '0, '0, 128'h00000000_00000000_00000000_00000001, 8'd0, "R3");
      cyc(1'b1, '0, '0, 128'h00000001_00000000_00000000_00000000, 8'd0, "R3");
      cyc(1'b1, '0, '0, 128'h00000000_00000100_00000010_00000000, 8'd40, "R3");
      // R4: ignored selector bits
      for (int i = 0; i < 4; i++) begin
         logic [127:0] x4, y4, m4;
         x4 = rnd128(); y4 = rnd128(); m4 = rnd128();
         cyc(1'b1, x4, y4, m4, 8'h0C, "R4");
         cyc(1'b1, x4, y4, m4, 8'hCD, "R4");
         cyc(1'b1, x4, y4, m4, 8'h7F, "R4");
      end
      // R5 / R6: constant and class boundary
      for (int i = 0; i < 3; i++) begin
         logic [127:0] x5, y5, m5;
         x5 = rnd128(); y5 = rnd128(); m5 = rnd128();
         cyc(1'b1, x5, y5, m5, 8'd14, "R5");
         cyc(1'b1, x5, y5, m5, 8'd16, "R6");
         cyc(1'b1, x5, y5, m5, 8'd30, "R5");
         cyc(1'b1, x5, y5, m5, 8'd32, "R5");
         cyc(1'b1, x5, y5, m5, 8'd62, "R6");
      end
      // R11: idle cycles with changing inputs
      for (int i = 0; i < 4; i++)
         cyc(1'b0, rnd128(), rnd128(), rnd128(), 8'($urandom), "R11");
      // R7: general rounds
      for (int i = 0; i < 64; i++)
         cyc(1'b1, rnd128(), rnd128(), rnd128(), 8'(i * 4 + 1), "R7");
      // R9: valid toggling
      for (int i = 0; i < 20; i++)
         cyc(1'(($urandom % 3) != 0), rnd128(), rnd128(), rnd128(), 8'($urandom), "R9");
      // R10: reset mid-stream with valid high
      cyc(1'b1, rnd128(), rnd128(), rnd128(), 8'd50, "R10", 1'b1);
      cyc(1'b0, '0, '0, '0, 8'd0, "R11");
      cyc(1'b1, rnd128(), rnd128(), rnd128(), 8'd6, "R7");
      cyc(1'b0, '0, '0, '0, 8'd0, "R11");
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule